// File: doc/BRIEF.md
# Split Address/Data Store Queue

This block keeps in-flight stores for a core that splits every store into two independent operations: an address half and a data half. A slot is claimed in program order when the store is dispatched. The address half and the data half then arrive on their own ports, in either order. As soon as the address half lands, it is compared against a small table of loads that have already executed. If a load that is younger in program order touched any of the same bytes, a violation pulse is raised, so the core can replay from that load.

Stores leave the queue only from the oldest slot, at most one per cycle. A slot leaves once it has been committed and holds both halves. It is then handed back to the load-store unit as a complete store of up to 128 bits. A flush discards every queued store, and every recorded load, that is younger than a given program-order tag.

Top module: `split_store_queue`

## Requirements
- R1: Slots are handed out in ring order, starting at slot 0 after reset. When all `SQ_DEPTH` slots are occupied, `alloc_ready` is low and an allocation request has no effect.
- R2: The address half and the data half of a slot may be written in either order. A store is reissued only once both are present, and it then carries the address, size and data that were written.
- R3: A store address covers bytes `addr` to `addr + 2**size - 1`. Tag `a` is younger than tag `b` when `(a - b) mod 2**SEQ_W` is non-zero and below `2**(SEQ_W-1)`. If a recorded load is younger than the store and its byte range overlaps the store's, `viol_valid` is high for exactly the cycle after the address write, and `viol_seq` gives the store's tag.
- R4: No violation is raised in two cases. One is a load that is not younger than the store. The other is a load whose byte range only touches the store's range without sharing a byte.
- R5: A reissue appears on `rs_*` one cycle after the oldest slot is committed and complete. Reissues come strictly oldest-first, one per cycle, and can be back-to-back.
- R6: A committed slot whose data half is missing is not reissued, and it holds back every younger slot.
- R7: A flush with tag `t` removes every queued store and every recorded load younger than `t`. The next allocation reuses the first freed slot, and a removed load no longer raises violations.
- R8: After reset, `alloc_ready` is 1, `alloc_slot` is 0, and `rs_valid` and `viol_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Claim a slot for a new store |
| alloc_seq | input | SEQ_W | Program-order tag of the new store |
| alloc_ready | output | 1 | A free slot exists |
| alloc_slot | output | IDX_W | Slot that the next allocation receives |
| sa_valid | input | 1 | Address half write |
| sa_slot | input | IDX_W | Slot addressed by the address half |
| sa_addr | input | ADDR_W | Store byte address |
| sa_size | input | SZ_W | log2 of store length in bytes |
| sd_valid | input | 1 | Data half write |
| sd_slot | input | IDX_W | Slot addressed by the data half |
| sd_data | input | DATA_W | Store data |
| ld_valid | input | 1 | Record an executed load |
| ld_seq | input | SEQ_W | Load program-order tag |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | SZ_W | log2 of load length in bytes |
| commit_valid | input | 1 | Mark the oldest uncommitted store as committed |
| flush_valid | input | 1 | Discard everything younger than `flush_seq` |
| flush_seq | input | SEQ_W | Flush boundary tag |
| rs_valid | output | 1 | Reissue to the load-store unit |
| rs_seq | output | SEQ_W | Tag of reissued store |
| rs_addr | output | ADDR_W | Address of reissued store |
| rs_size | output | SZ_W | Size of reissued store |
| rs_data | output | DATA_W | Data of reissued store |
| viol_valid | output | 1 | Ordering violation pulse |
| viol_seq | output | SEQ_W | Tag of the store that found the violation |

## Verification
The bench builds the block with a queue of 4 slots, a load table of 4 entries, 16-bit addresses, 6-bit tags and the full 128-bit data path. With only four slots, a handful of allocations fills the queue, so the stall and the ring wrap back to slot 0 are both reached. A flush can also be shown to rewind the allocation point into the middle of the ring. The small tag width keeps the modular younger/older comparison in play with short test sequences.

// File: rtl/sab_pkg.sv
package sab_pkg;

  // a is younger than b in a modular tag space of w bits
  function automatic logic seq_younger(input logic [31:0] a, input logic [31:0] b,
                                       input int unsigned w);
    logic [31:0] d;
    logic [31:0] m;
    d = a - b;
    m = (32'd1 << w) - 32'd1;
    return ((d & m) != 32'd0) && (d[w-1] == 1'b0);
  endfunction

  // byte ranges [a, a+2**as) and [b, b+2**bs) share at least one byte
  function automatic logic ranges_overlap(input logic [63:0] a, input logic [7:0] as,
                                          input logic [63:0] b, input logic [7:0] bs);
    return (a < b + (64'd1 << bs)) && (b < a + (64'd1 << as));
  endfunction

endpackage

// File: rtl/sab_data_ram.sv
module sab_data_ram #(
  parameter int DEPTH  = 36,
  parameter int DATA_W = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // one write port, one registered read port: block RAM shaped
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/sab_flush_keep.sv
module sab_flush_keep
  import sab_pkg::*;
#(
  parameter int DEPTH = 36,
  parameter int SEQ_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0]            occ,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seqs,
  input  logic [SEQ_W-1:0]            flush_seq,
  output logic [DEPTH-1:0]            keep,
  output logic [CNT_W-1:0]            kept
);

  // survivors form a contiguous prefix from the head, so their count sets the new tail
  always_comb begin
    kept = '0;
    for (int i = 0; i < DEPTH; i++) begin
      keep[i] = occ[i] && !seq_younger(32'(seqs[i]), 32'(flush_seq), SEQ_W);
      kept = kept + CNT_W'(keep[i]);
    end
  end

endmodule

// File: rtl/sab_load_table.sv
module sab_load_table
  import sab_pkg::*;
#(
  parameter int LT_DEPTH = 64,
  parameter int ADDR_W   = 32,
  parameter int SEQ_W    = 8,
  parameter int SZ_W     = 3,
  localparam int LT_IDX_W = (LT_DEPTH > 1) ? $clog2(LT_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [SEQ_W-1:0]  ld_seq,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SZ_W-1:0]   ld_size,
  input  logic              flush_valid,
  input  logic [SEQ_W-1:0]  flush_seq,
  input  logic              drop_valid,
  input  logic [SEQ_W-1:0]  drop_seq,
  input  logic [SEQ_W-1:0]  chk_seq,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [SZ_W-1:0]   chk_size,
  output logic              hit
);

  logic [LT_DEPTH-1:0] vld;
  logic [SEQ_W-1:0]    lseq  [LT_DEPTH];
  logic [ADDR_W-1:0]   laddr [LT_DEPTH];
  logic [SZ_W-1:0]     lsize [LT_DEPTH];
  logic [LT_IDX_W-1:0] wptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= '0;
      wptr <= '0;
    end else begin
      for (int i = 0; i < LT_DEPTH; i++) begin
        // loads older than a draining store can never conflict again
        if (drop_valid && !seq_younger(32'(lseq[i]), 32'(drop_seq), SEQ_W)) vld[i] <= 1'b0;
        if (flush_valid && seq_younger(32'(lseq[i]), 32'(flush_seq), SEQ_W)) vld[i] <= 1'b0;
        if (ld_valid && wptr == LT_IDX_W'(i)) begin
          vld[i]   <= 1'b1;
          lseq[i]  <= ld_seq;
          laddr[i] <= ld_addr;
          lsize[i] <= ld_size;
        end
      end
      if (ld_valid) wptr <= (wptr == LT_IDX_W'(LT_DEPTH - 1)) ? '0 : wptr + 1'b1;
    end
  end

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < LT_DEPTH; i++) begin
      if (vld[i] && seq_younger(32'(lseq[i]), 32'(chk_seq), SEQ_W) &&
          ranges_overlap(64'(laddr[i]), 8'(lsize[i]), 64'(chk_addr), 8'(chk_size)))
        hit = 1'b1;
    end
  end

  // R3: a recorded load is visible to the next check
  p_load_recorded_r3: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> vld[$past(wptr)]);

endmodule

// File: rtl/split_store_queue.sv
module split_store_queue
  import sab_pkg::*;
#(
  parameter int SQ_DEPTH = 36,
  parameter int LT_DEPTH = 64,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 128,
  parameter int SEQ_W    = 8,
  parameter int SZ_W     = 3,
  localparam int IDX_W   = $clog2(SQ_DEPTH),
  localparam int CNT_W   = $clog2(SQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_slot,
  input  logic              sa_valid,
  input  logic [IDX_W-1:0]  sa_slot,
  input  logic [ADDR_W-1:0] sa_addr,
  input  logic [SZ_W-1:0]   sa_size,
  input  logic              sd_valid,
  input  logic [IDX_W-1:0]  sd_slot,
  input  logic [DATA_W-1:0] sd_data,
  input  logic              ld_valid,
  input  logic [SEQ_W-1:0]  ld_seq,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SZ_W-1:0]   ld_size,
  input  logic              commit_valid,
  input  logic              flush_valid,
  input  logic [SEQ_W-1:0]  flush_seq,
  output logic              rs_valid,
  output logic [SEQ_W-1:0]  rs_seq,
  output logic [ADDR_W-1:0] rs_addr,
  output logic [SZ_W-1:0]   rs_size,
  output logic [DATA_W-1:0] rs_data,
  output logic              viol_valid,
  output logic [SEQ_W-1:0]  viol_seq
);

  logic [SQ_DEPTH-1:0]            occ, av, dv;
  logic [SQ_DEPTH-1:0][SEQ_W-1:0] seq_q;
  logic [ADDR_W-1:0]              addr_q [SQ_DEPTH];
  logic [SZ_W-1:0]                size_q [SQ_DEPTH];
  logic [IDX_W-1:0]               head, tail;
  logic [CNT_W-1:0]               count, ncommit;

  logic             alloc_fire, commit_fire, drain, lt_hit;
  logic [SQ_DEPTH-1:0] keep;
  logic [CNT_W-1:0]    kept;

  function automatic logic [IDX_W-1:0] ring_add(input logic [IDX_W-1:0] p, input logic [CNT_W-1:0] n);
    int s;
    s = int'(p) + int'(n);
    if (s >= SQ_DEPTH) s = s - SQ_DEPTH;
    return IDX_W'(s);
  endfunction

  assign alloc_ready = (count != CNT_W'(SQ_DEPTH));
  assign alloc_slot  = tail;
  assign alloc_fire  = alloc_valid && alloc_ready && !flush_valid;
  assign commit_fire = commit_valid && (ncommit < count);
  assign drain       = (ncommit != '0) && av[head] && dv[head];

  sab_flush_keep #(.DEPTH(SQ_DEPTH), .SEQ_W(SEQ_W)) u_keep (
    .occ(occ), .seqs(seq_q), .flush_seq(flush_seq), .keep(keep), .kept(kept)
  );

  sab_load_table #(.LT_DEPTH(LT_DEPTH), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .SZ_W(SZ_W)) u_loads (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_seq(ld_seq), .ld_addr(ld_addr), .ld_size(ld_size),
    .flush_valid(flush_valid), .flush_seq(flush_seq),
    .drop_valid(drain), .drop_seq(seq_q[head]),
    .chk_seq(seq_q[sa_slot]), .chk_addr(sa_addr), .chk_size(sa_size),
    .hit(lt_hit)
  );

  sab_data_ram #(.DEPTH(SQ_DEPTH), .DATA_W(DATA_W)) u_data (
    .clk(clk), .we(sd_valid), .waddr(sd_slot), .wdata(sd_data),
    .re(drain), .raddr(head), .rdata(rs_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      head       <= '0;
      tail       <= '0;
      count      <= '0;
      ncommit    <= '0;
      occ        <= '0;
      av         <= '0;
      dv         <= '0;
      rs_valid   <= 1'b0;
      rs_seq     <= '0;
      rs_addr    <= '0;
      rs_size    <= '0;
      viol_valid <= 1'b0;
      viol_seq   <= '0;
    end else begin
      rs_valid <= drain;
      if (drain) begin
        rs_seq  <= seq_q[head];
        rs_addr <= addr_q[head];
        rs_size <= size_q[head];
      end
      viol_valid <= sa_valid && lt_hit;
      viol_seq   <= seq_q[sa_slot];

      ncommit <= ncommit + CNT_W'(commit_fire) - CNT_W'(drain);
      if (drain) head <= ring_add(head, CNT_W'(1));

      if (flush_valid) begin
        tail  <= ring_add(head, kept);
        count <= kept - CNT_W'(drain);
      end else begin
        if (alloc_fire) tail <= ring_add(tail, CNT_W'(1));
        count <= count + CNT_W'(alloc_fire) - CNT_W'(drain);
      end

      for (int i = 0; i < SQ_DEPTH; i++) begin
        if (alloc_fire && tail == IDX_W'(i)) begin
          occ[i]   <= 1'b1;
          av[i]    <= 1'b0;
          dv[i]    <= 1'b0;
          seq_q[i] <= alloc_seq;
        end
        if (sa_valid && sa_slot == IDX_W'(i)) begin
          av[i]     <= 1'b1;
          addr_q[i] <= sa_addr;
          size_q[i] <= sa_size;
        end
        if (sd_valid && sd_slot == IDX_W'(i)) dv[i] <= 1'b1;
        if ((drain && head == IDX_W'(i)) || (flush_valid && !keep[i])) begin
          occ[i] <= 1'b0;
          av[i]  <= 1'b0;
          dv[i]  <= 1'b0;
        end
      end
    end
  end

  // R1: a full queue stays full unless something leaves
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    (!alloc_ready && !drain && !flush_valid) |=> !alloc_ready);

  // R2: halves are only written into claimed slots
  p_half_to_live_slot_r2: assert property (@(posedge clk) disable iff (rst)
    (sa_valid || sd_valid) |-> (occ[sa_valid ? sa_slot : sd_slot]));

  // R3: a violation always follows an address write
  p_viol_after_addr_r3: assert property (@(posedge clk) disable iff (rst)
    viol_valid |-> $past(sa_valid));

  // R5: consecutive reissues are strictly oldest-first
  p_oldest_first_r5: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && $past(rs_valid)) |-> seq_younger(32'(rs_seq), 32'($past(rs_seq)), SEQ_W));

  // R6: only committed stores are reissued
  p_commit_before_reissue_r6: assert property (@(posedge clk) disable iff (rst)
    rs_valid |-> $past(ncommit != '0));

endmodule

// File: tb/sim_split_store_queue.sv
module sim_split_store_queue;

  localparam int D  = 4;
  localparam int LT = 4;
  localparam int AW = 16;
  localparam int DW = 128;
  localparam int SW = 6;
  localparam int ZW = 3;
  localparam int IW = $clog2(D);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          alloc_valid = 0, alloc_ready;
  logic [SW-1:0] alloc_seq = '0;
  logic [IW-1:0] alloc_slot;
  logic          sa_valid = 0, sd_valid = 0, ld_valid = 0, commit_valid = 0, flush_valid = 0;
  logic [IW-1:0] sa_slot = '0, sd_slot = '0;
  logic [AW-1:0] sa_addr = '0, ld_addr = '0;
  logic [ZW-1:0] sa_size = '0, ld_size = '0;
  logic [DW-1:0] sd_data = '0;
  logic [SW-1:0] ld_seq = '0, flush_seq = '0;
  logic          rs_valid, viol_valid;
  logic [SW-1:0] rs_seq, viol_seq;
  logic [AW-1:0] rs_addr;
  logic [ZW-1:0] rs_size;
  logic [DW-1:0] rs_data;

  split_store_queue #(.SQ_DEPTH(D), .LT_DEPTH(LT), .ADDR_W(AW), .DATA_W(DW),
                      .SEQ_W(SW), .SZ_W(ZW)) u0 (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_ready(alloc_ready), .alloc_slot(alloc_slot),
    .sa_valid(sa_valid), .sa_slot(sa_slot), .sa_addr(sa_addr), .sa_size(sa_size),
    .sd_valid(sd_valid), .sd_slot(sd_slot), .sd_data(sd_data),
    .ld_valid(ld_valid), .ld_seq(ld_seq), .ld_addr(ld_addr), .ld_size(ld_size),
    .commit_valid(commit_valid), .flush_valid(flush_valid), .flush_seq(flush_seq),
    .rs_valid(rs_valid), .rs_seq(rs_seq), .rs_addr(rs_addr), .rs_size(rs_size), .rs_data(rs_data),
    .viol_valid(viol_valid), .viol_seq(viol_seq)
  );

  typedef struct packed {
    logic [SW-1:0] seq;
    logic [AW-1:0] addr;
    logic [ZW-1:0] size;
    logic [DW-1:0] data;
  } exp_t;

  exp_t expq[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: every reissue must match the oldest expected store
  always @(negedge clk) begin
    if (!rst && rs_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R5 unexpected reissue", DW'(rs_seq), '0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(rs_seq == e.seq && rs_addr == e.addr && rs_size == e.size && rs_data == e.data,
              "R2 reissue contents", rs_data ^ DW'(rs_seq), e.data ^ DW'(e.seq));
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_alloc(input logic [SW-1:0] s, input logic [IW-1:0] exp_slot, input string req);
    check(alloc_slot == exp_slot && alloc_ready, req, DW'(alloc_slot), DW'(exp_slot));
    alloc_valid = 1; alloc_seq = s;
    step();
    alloc_valid = 0;
  endtask

  task automatic do_sa(input logic [IW-1:0] sl, input logic [AW-1:0] a, input logic [ZW-1:0] z);
    sa_valid = 1; sa_slot = sl; sa_addr = a; sa_size = z;
    step();
    sa_valid = 0;
  endtask

  task automatic do_sd(input logic [IW-1:0] sl, input logic [DW-1:0] d);
    sd_valid = 1; sd_slot = sl; sd_data = d;
    step();
    sd_valid = 0;
  endtask

  task automatic do_load(input logic [SW-1:0] s, input logic [AW-1:0] a, input logic [ZW-1:0] z);
    ld_valid = 1; ld_seq = s; ld_addr = a; ld_size = z;
    step();
    ld_valid = 0;
  endtask

  task automatic do_commit();
    commit_valid = 1;
    step();
    commit_valid = 0;
  endtask

  task automatic do_flush(input logic [SW-1:0] s);
    flush_valid = 1; flush_seq = s;
    step();
    flush_valid = 0;
  endtask

  function automatic exp_t mk(input logic [SW-1:0] s, input logic [AW-1:0] a,
                              input logic [ZW-1:0] z, input logic [DW-1:0] d);
    exp_t e;
    e.seq = s; e.addr = a; e.size = z; e.data = d;
    return e;
  endfunction

  localparam logic [DW-1:0] D0 = 128'h0123_4567_89ab_cdef_0011_2233_4455_6677;
  localparam logic [DW-1:0] D1 = 128'hfeed_0001_0002_0003_0004_0005_0006_0007;
  localparam logic [DW-1:0] D2 = 128'h2222_aaaa;
  localparam logic [DW-1:0] D3 = 128'h3333_bbbb_cccc_dddd_eeee_ffff_1234_5678;
  localparam logic [DW-1:0] D4 = 128'h4444;
  localparam logic [DW-1:0] D5 = 128'h5555_0000_0000_0000_0000_0000_0000_0001;

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    // R8 reset state
    check(alloc_ready == 1'b1, "R8 alloc_ready", DW'(alloc_ready), 1);
    check(alloc_slot == '0, "R8 alloc_slot", DW'(alloc_slot), 0);
    check(rs_valid == 1'b0 && viol_valid == 1'b0, "R8 outputs idle", DW'({rs_valid, viol_valid}), 0);

    do_load(6'd0, 16'h0200, 3'd3);   // older than every store below
    do_load(6'd5, 16'h0100, 3'd2);   // bytes 0x100..0x103, younger than stores 1..4

    // R1 ring order and full stall
    do_alloc(6'd1, 2'd0, "R1 slot 0");
    do_alloc(6'd2, 2'd1, "R1 slot 1");
    do_alloc(6'd3, 2'd2, "R1 slot 2");
    do_alloc(6'd4, 2'd3, "R1 slot 3");
    check(alloc_ready == 1'b0, "R1 full stalls", DW'(alloc_ready), 0);
    alloc_valid = 1; alloc_seq = 6'd9;
    step();
    alloc_valid = 0;
    check(alloc_ready == 1'b0 && alloc_slot == 2'd0, "R1 alloc ignored when full",
          DW'({alloc_ready, alloc_slot}), 0);

    // R3 overlap with younger load
    do_sa(2'd1, 16'h0102, 3'd0);
    check(viol_valid == 1'b1 && viol_seq == 6'd2, "R3 violation", DW'({viol_valid, viol_seq}), DW'({1'b1, 6'd2}));
    step();
    check(viol_valid == 1'b0, "R3 one-cycle pulse", DW'(viol_valid), 0);
    // R4 adjacent range, no shared byte
    do_sa(2'd0, 16'h0104, 3'd2);
    check(viol_valid == 1'b0, "R4 adjacent no violation", DW'(viol_valid), 0);
    // R4 older load overlapping
    do_sa(2'd2, 16'h0200, 3'd0);
    check(viol_valid == 1'b0, "R4 older load ignored", DW'(viol_valid), 0);

    // R6 committed head without data blocks younger complete store
    do_sd(2'd1, D1);
    do_commit();
    do_commit();
    for (int k = 0; k < 3; k++) begin
      check(rs_valid == 1'b0, "R6 head waits for data", DW'(rs_valid), 0);
      step();
    end

    // R5 back-to-back, oldest first
    expq.push_back(mk(6'd1, 16'h0104, 3'd2, D0));
    expq.push_back(mk(6'd2, 16'h0102, 3'd0, D1));
    do_sd(2'd0, D0);
    step();
    check(rs_valid && rs_seq == 6'd1, "R5 oldest reissued first", DW'(rs_seq), 1);
    step();
    check(rs_valid && rs_seq == 6'd2, "R5 next reissued back-to-back", DW'(rs_seq), 2);

    // R2 data before address
    do_sd(2'd3, D3);
    do_sd(2'd2, D2);
    expq.push_back(mk(6'd3, 16'h0200, 3'd0, D2));
    expq.push_back(mk(6'd4, 16'h0400, 3'd4, D3));
    do_commit();
    do_commit();
    do_sa(2'd3, 16'h0400, 3'd4);
    check(viol_valid == 1'b0, "R4 disjoint 16-byte store", DW'(viol_valid), 0);
    repeat (4) step();
    check(expq.size() == 0, "R2 all halves combined and reissued", DW'(expq.size()), 0);

    // R7 flush rewinds allocation and removes younger loads
    do_alloc(6'd10, 2'd0, "R1 wrap to slot 0");
    do_alloc(6'd11, 2'd1, "R7 pre-flush slot 1");
    do_alloc(6'd12, 2'd2, "R7 pre-flush slot 2");
    do_load(6'd13, 16'h0300, 3'd1);
    do_flush(6'd10);
    check(alloc_slot == 2'd1 && alloc_ready, "R7 flush frees younger slots", DW'(alloc_slot), 1);
    do_alloc(6'd11, 2'd1, "R7 reuse freed slot");
    do_sa(2'd1, 16'h0300, 3'd0);
    check(viol_valid == 1'b0, "R7 flushed load gone", DW'(viol_valid), 0);
    do_load(6'd14, 16'h0300, 3'd0);
    do_sa(2'd1, 16'h0300, 3'd0);
    check(viol_valid == 1'b1 && viol_seq == 6'd11, "R3 new younger load flags",
          DW'({viol_valid, viol_seq}), DW'({1'b1, 6'd11}));

    expq.push_back(mk(6'd10, 16'h0500, 3'd0, D4));
    expq.push_back(mk(6'd11, 16'h0300, 3'd0, D5));
    do_sa(2'd0, 16'h0500, 3'd0);
    do_sd(2'd0, D4);
    do_sd(2'd1, D5);
    do_commit();
    do_commit();
    repeat (5) step();
    check(expq.size() == 0, "R5 survivors drained in order", DW'(expq.size()), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule